// File: doc/BRIEF.md
# Low-Power Exit Sequencer

This controller brings a chip out of its combined core-and-system sleep state and back to full operation. Low-power entry logic elsewhere pulses `enter_req` with a mode code. From then on the sequencer holds the quiesce indication and the sleep-enable control bit high. It also keeps every bus-master request away from the arbiter. While sleeping it waits for a wake condition: a timer wake from the processor core, or any bus master raising a request.

On wake, the restore order is fixed. If the memory was put to sleep (a flag captured at entry), the memory controller and its DLL are enabled first. Memory clocks run and self-refresh is left only once the DLL reports lock. A programmable timeout stops this wait from hanging and records a sticky error. Next, the remaining units are enabled and the core is interrupted. Once every unit and the core report ready, the sequencer returns to full-on. It clears quiesce and sleep-enable and opens the request path in that same cycle.

A core-only nap mode is also handled: only the core's memory-access grant is withdrawn, and it is restored one cycle after the core reports ready. Doze needs no action here.

Top module: `lpx_exit_seq`

## Requirements
- R1: After reset the block is in full-on: `quiesce`=0, `sleep_en`=0, `mem_ctl_en`=`dll_en`=`mclk_en`=`units_en`=1, `core_mem_gnt`=1, `core_irq`=0, `sr_exit`=0, `dll_err`=0.
- R2: `enter_req` with `enter_mode` 2'b00 (none) or 2'b01 (doze) changes no output.
- R3: `enter_mode` 2'b10 (nap) drops `core_mem_gnt` one cycle after the request while `quiesce` stays 0 and bus requests keep passing; `core_mem_gnt` returns one cycle after `core_rdy` is sampled high.
- R4: `enter_mode` 2'b11 (system) sets `quiesce` and `sleep_en` one cycle after the request and clears `units_en`; when `mem_lp_en` was 1 at that request, `mem_ctl_en`, `dll_en` and `mclk_en` also drop.
- R5: During system sleep, `core_tb_wake` or any `bus_req` bit is registered once; the second rising edge after it is driven starts the exit, and with no wake source the sleep state holds.
- R6: With memory slept, the exit first raises `mem_ctl_en` and `dll_en` with `mclk_en` low; `mclk_en` rises, together with a one-cycle `sr_exit` pulse, only on the cycle after lock (or timeout) is sampled.
- R7: The lock counter starts at 0 on entry to the wait. If `dll_lock` is first sampled L cycles after `dll_en` is seen and the threshold is `lock_tmo`=T, then memory resumes after min(L,T)+1 cycles. `dll_err` is set exactly when L>T. The sequence continues, and `dll_err` holds until reset.
- R8: The memory flag is captured at the system-entry request; later changes of `mem_lp_en` do not alter the exit path.
- R9: `units_en` and `core_irq` rise one cycle after memory resumes (or one cycle after the wake is registered when memory was not slept); `core_irq` stays high until `core_irq_ack` is sampled.
- R10: Full-on is reached two cycles after the last of `unit_rdy` and `core_rdy` goes high (registered AND); `quiesce` and `sleep_en` fall and `core_mem_gnt` rises in that same cycle.
- R11: `bus_req_out` is all zero throughout system sleep and equals `bus_req` combinationally from full-on onwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enter_req | input | 1 | Low-power entry pulse from the entry logic |
| enter_mode | input | 2 | 00 none, 01 doze, 10 nap, 11 system |
| mem_lp_en | input | 1 | Memory sleep flag, captured at system entry |
| lock_tmo | input | TMO_W | DLL lock wait threshold in cycles |
| core_tb_wake | input | 1 | Timer wake from the core |
| bus_req | input | NUM_MASTERS | Pending bus-master requests |
| dll_lock | input | 1 | DLL lock indication |
| unit_rdy | input | NUM_UNITS | Per-unit ready |
| core_rdy | input | 1 | Core ready |
| core_irq_ack | input | 1 | Core acknowledges the wake interrupt |
| quiesce | output | 1 | System quiesced |
| sleep_en | output | 1 | Sleep-enable control bit |
| mem_ctl_en | output | 1 | Memory controller enable |
| dll_en | output | 1 | DLL enable |
| mclk_en | output | 1 | Memory clock output enable |
| sr_exit | output | 1 | One-cycle command to leave self-refresh |
| units_en | output | 1 | Enable for remaining internal units |
| core_irq | output | 1 | Wake interrupt to the core |
| core_mem_gnt | output | 1 | Core access to memory controller |
| dll_err | output | 1 | Sticky lock-timeout flag |
| bus_req_out | output | NUM_MASTERS | Requests forwarded to the arbiter |

## Verification
The bench sweeps memory flag, wake source, lock delay and timeout threshold, and checks the cycle at which memory clocks start. A design that gave the timeout priority over a lock arriving on the same cycle would flag an error when L equals T. One that ignored the saved flag would take the DLL path after the flag was flipped during sleep. Ready inputs are raised one at a time in a rotating order, and `core_irq` is left unacknowledged for several cycles. This catches a premature return to full-on on a partial AND, an interrupt that drops by itself, and request forwarding that leaks during sleep. Nap and doze entries are checked to leave quiesce and the request path alone.

// File: rtl/lpx_pkg.sv
package lpx_pkg;

    localparam logic [1:0] MODE_NONE = 2'b00;
    localparam logic [1:0] MODE_DOZE = 2'b01;
    localparam logic [1:0] MODE_NAP  = 2'b10;
    localparam logic [1:0] MODE_SYS  = 2'b11;

    typedef enum logic [2:0] {
        S_FULL_ON    = 3'd0,
        S_NAP        = 3'd1,
        S_SYS_IDLE   = 3'd2,
        S_DLL_WAIT   = 3'd3,
        S_MEM_RESUME = 3'd4,
        S_UNITS      = 3'd5
    } lpx_state_e;

    typedef struct packed {
        lpx_state_e state;
        logic       mem_slept;
        logic       quiesce;
        logic       slp_en;
        logic       mem_en;
        logic       dll_en;
        logic       mclk_en;
        logic       sr_exit;
        logic       units_en;
        logic       core_irq;
        logic       mem_gnt;
        logic       bus_open;
        logic       dll_err;
    } lpx_regs_t;

    localparam lpx_regs_t LPX_RESET = '{
        state:     S_FULL_ON,
        mem_slept: 1'b0,
        quiesce:   1'b0,
        slp_en:    1'b0,
        mem_en:    1'b1,
        dll_en:    1'b1,
        mclk_en:   1'b1,
        sr_exit:   1'b0,
        units_en:  1'b1,
        core_irq:  1'b0,
        mem_gnt:   1'b1,
        bus_open:  1'b1,
        dll_err:   1'b0
    };

endpackage

// File: rtl/lpx_wake_detect.sv
module lpx_wake_detect #(
    parameter int NUM_MASTERS = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   arm,
    input  logic                   timer_wake,
    input  logic [NUM_MASTERS-1:0] req,
    output logic                   wake_q
);

    // prefix OR across the masters, one stage per requester
    logic [NUM_MASTERS:0] any_req;
    assign any_req[0] = 1'b0;

    for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_req_or
        assign any_req[g+1] = any_req[g] | req[g];
    end

    logic wake_d;

    always_comb begin
        wake_d = arm & (timer_wake | any_req[NUM_MASTERS]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wake_q <= 1'b0;
        else        wake_q <= wake_d;
    end

    // a registered wake only exists when the detector was armed (R5)
    p_wake_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> $past(arm));

endmodule

// File: rtl/lpx_lock_timer.sv
module lpx_lock_timer #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMO_W-1:0] tmo,
    output logic             expired
);

    localparam logic [TMO_W-1:0] CNT_MAX = '1;

    logic [TMO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expired = run && (cnt_q >= tmo);
        if (!run)
            cnt_d = '0;
        else if (cnt_q != CNT_MAX && !expired)
            cnt_d = cnt_q + 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // counter freezes once expired while still running (R7)
    p_cnt_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && expired) |=> (!run || $stable(cnt_q)));

    // a stopped timer restarts from zero (R7)
    p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/lpx_ready_and.sv
module lpx_ready_and #(
    parameter int NUM_UNITS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arm,
    input  logic [NUM_UNITS-1:0] unit_rdy,
    input  logic                 core_rdy,
    output logic                 all_rdy_q
);

    localparam int NUM_SRC = NUM_UNITS + 1;

    logic [NUM_SRC-1:0] src;
    logic [NUM_SRC:0]   chain;

    assign src     = {core_rdy, unit_rdy};
    assign chain[0] = 1'b1;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_rdy_and
        assign chain[g+1] = chain[g] & src[g];
    end

    logic all_rdy_d;

    always_comb begin
        all_rdy_d = arm & chain[NUM_SRC];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) all_rdy_q <= 1'b0;
        else        all_rdy_q <= all_rdy_d;
    end

    // registered ready implies every source was high one cycle earlier (R10)
    p_and_registered_r10: assert property (@(posedge clk) disable iff (!rst_n)
        all_rdy_q |-> ($past(core_rdy) && ($past(unit_rdy) == {NUM_UNITS{1'b1}})));

endmodule

// File: rtl/lpx_exit_seq.sv
module lpx_exit_seq
    import lpx_pkg::*;
#(
    parameter int NUM_MASTERS = 3,
    parameter int NUM_UNITS   = 4,
    parameter int TMO_W       = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enter_req,
    input  logic [1:0]             enter_mode,
    input  logic                   mem_lp_en,
    input  logic [TMO_W-1:0]       lock_tmo,
    input  logic                   core_tb_wake,
    input  logic [NUM_MASTERS-1:0] bus_req,
    input  logic                   dll_lock,
    input  logic [NUM_UNITS-1:0]   unit_rdy,
    input  logic                   core_rdy,
    input  logic                   core_irq_ack,
    output logic                   quiesce,
    output logic                   sleep_en,
    output logic                   mem_ctl_en,
    output logic                   dll_en,
    output logic                   mclk_en,
    output logic                   sr_exit,
    output logic                   units_en,
    output logic                   core_irq,
    output logic                   core_mem_gnt,
    output logic                   dll_err,
    output logic [NUM_MASTERS-1:0] bus_req_out
);

    lpx_regs_t r_d, r_q;

    logic wake_q;
    logic tmo_exp;
    logic all_rdy_q;
    logic wake_arm, lock_run, rdy_arm;

    assign wake_arm = (r_q.state == S_SYS_IDLE);
    assign lock_run = (r_q.state == S_DLL_WAIT);
    assign rdy_arm  = (r_q.state == S_UNITS);

    lpx_wake_detect #(.NUM_MASTERS(NUM_MASTERS)) i_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (wake_arm),
        .timer_wake (core_tb_wake),
        .req        (bus_req),
        .wake_q     (wake_q)
    );

    lpx_lock_timer #(.TMO_W(TMO_W)) i_lock_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (lock_run),
        .tmo     (lock_tmo),
        .expired (tmo_exp)
    );

    lpx_ready_and #(.NUM_UNITS(NUM_UNITS)) i_ready (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (rdy_arm),
        .unit_rdy  (unit_rdy),
        .core_rdy  (core_rdy),
        .all_rdy_q (all_rdy_q)
    );

    always_comb begin
        r_d         = r_q;
        r_d.sr_exit = 1'b0;

        if (r_q.core_irq && core_irq_ack)
            r_d.core_irq = 1'b0;

        unique case (r_q.state)
            S_FULL_ON: begin
                if (enter_req) begin
                    if (enter_mode == MODE_NAP) begin
                        r_d.state   = S_NAP;
                        r_d.mem_gnt = 1'b0;
                    end else if (enter_mode == MODE_SYS) begin
                        r_d.state     = S_SYS_IDLE;
                        r_d.quiesce   = 1'b1;
                        r_d.slp_en    = 1'b1;
                        r_d.bus_open  = 1'b0;
                        r_d.units_en  = 1'b0;
                        r_d.mem_gnt   = 1'b0;
                        r_d.mem_slept = mem_lp_en;
                        if (mem_lp_en) begin
                            r_d.mem_en  = 1'b0;
                            r_d.dll_en  = 1'b0;
                            r_d.mclk_en = 1'b0;
                        end
                    end
                end
            end

            S_NAP: begin
                if (core_rdy) begin
                    r_d.state   = S_FULL_ON;
                    r_d.mem_gnt = 1'b1;
                end
            end

            S_SYS_IDLE: begin
                if (wake_q) begin
                    if (r_q.mem_slept) begin
                        r_d.state  = S_DLL_WAIT;
                        r_d.mem_en = 1'b1;
                        r_d.dll_en = 1'b1;
                    end else begin
                        r_d.state    = S_UNITS;
                        r_d.units_en = 1'b1;
                        r_d.core_irq = 1'b1;
                    end
                end
            end

            S_DLL_WAIT: begin
                if (dll_lock || tmo_exp) begin
                    r_d.state   = S_MEM_RESUME;
                    r_d.mclk_en = 1'b1;
                    r_d.sr_exit = 1'b1;
                    if (!dll_lock)
                        r_d.dll_err = 1'b1;
                end
            end

            S_MEM_RESUME: begin
                r_d.state    = S_UNITS;
                r_d.units_en = 1'b1;
                r_d.core_irq = 1'b1;
            end

            S_UNITS: begin
                if (all_rdy_q) begin
                    r_d.state     = S_FULL_ON;
                    r_d.quiesce   = 1'b0;
                    r_d.slp_en    = 1'b0;
                    r_d.bus_open  = 1'b1;
                    r_d.mem_gnt   = 1'b1;
                    r_d.mem_slept = 1'b0;
                end
            end

            default: r_d = LPX_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= LPX_RESET;
        else        r_q <= r_d;
    end

    assign quiesce      = r_q.quiesce;
    assign sleep_en     = r_q.slp_en;
    assign mem_ctl_en   = r_q.mem_en;
    assign dll_en       = r_q.dll_en;
    assign mclk_en      = r_q.mclk_en;
    assign sr_exit      = r_q.sr_exit;
    assign units_en     = r_q.units_en;
    assign core_irq     = r_q.core_irq;
    assign core_mem_gnt = r_q.mem_gnt;
    assign dll_err      = r_q.dll_err;
    assign bus_req_out  = bus_req & {NUM_MASTERS{r_q.bus_open}};

    // no request reaches the arbiter while quiesced (R11)
    p_quiet_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        quiesce |-> (bus_req_out == '0));

    // memory clocks stay off while the DLL wait is unresolved (R6)
    p_clk_after_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_run && !dll_lock && !tmo_exp) |=> !mclk_en);

    // self-refresh exit is a single-cycle pulse (R6)
    p_sr_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sr_exit |=> !sr_exit);

    // units come up only after memory clocks when memory was slept (R6)
    p_mem_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(units_en) && r_q.mem_slept) |-> mclk_en);

    // quiesce and sleep-enable fall together, after the ready AND (R10)
    p_exit_together_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(quiesce) |-> ($fell(sleep_en) && $past(all_rdy_q)));

    // wake interrupt held until acknowledged (R9)
    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (core_irq && !core_irq_ack) |=> core_irq);

    // lock-timeout flag is sticky (R7)
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dll_err |=> dll_err);

endmodule

// File: tb/test_lpx_exit_seq.sv
module test_lpx_exit_seq;

    localparam int NM = 3;
    localparam int NU = 4;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          enter_req;
    logic [1:0]    enter_mode;
    logic          mem_lp_en;
    logic [TW-1:0] lock_tmo;
    logic          core_tb_wake;
    logic [NM-1:0] bus_req;
    logic          dll_lock;
    logic [NU-1:0] unit_rdy;
    logic          core_rdy;
    logic          core_irq_ack;
    logic          quiesce, sleep_en, mem_ctl_en, dll_en, mclk_en, sr_exit;
    logic          units_en, core_irq, core_mem_gnt, dll_err;
    logic [NM-1:0] bus_req_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lpx_exit_seq #(.NUM_MASTERS(NM), .NUM_UNITS(NU), .TMO_W(TW)) i_lpx_exit_seq (
        .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .enter_mode(enter_mode),
        .mem_lp_en(mem_lp_en), .lock_tmo(lock_tmo), .core_tb_wake(core_tb_wake),
        .bus_req(bus_req), .dll_lock(dll_lock), .unit_rdy(unit_rdy),
        .core_rdy(core_rdy), .core_irq_ack(core_irq_ack), .quiesce(quiesce),
        .sleep_en(sleep_en), .mem_ctl_en(mem_ctl_en), .dll_en(dll_en),
        .mclk_en(mclk_en), .sr_exit(sr_exit), .units_en(units_en),
        .core_irq(core_irq), .core_mem_gnt(core_mem_gnt), .dll_err(dll_err),
        .bus_req_out(bus_req_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic inputs_idle();
        enter_req    = 1'b0;
        enter_mode   = 2'b00;
        mem_lp_en    = 1'b0;
        core_tb_wake = 1'b0;
        bus_req      = '0;
        dll_lock     = 1'b0;
        unit_rdy     = '0;
        core_rdy     = 1'b0;
        core_irq_ack = 1'b0;
    endtask

    task automatic reset_dut();
        @(negedge clk);
        inputs_idle();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // all outputs at their full-on values
    task automatic chk_full_on(input string tag);
        chk({tag, " quiesce"},   quiesce, 0);
        chk({tag, " sleep_en"},  sleep_en, 0);
        chk({tag, " mem_ctl_en"}, mem_ctl_en, 1);
        chk({tag, " dll_en"},    dll_en, 1);
        chk({tag, " mclk_en"},   mclk_en, 1);
        chk({tag, " units_en"},  units_en, 1);
        chk({tag, " mem_gnt"},   core_mem_gnt, 1);
        chk({tag, " core_irq"},  core_irq, 0);
        chk({tag, " sr_exit"},   sr_exit, 0);
    endtask

    task automatic run_doze();
        reset_dut();
        chk_full_on("R1 reset");
        chk("R1 dll_err", dll_err, 0);
        for (int md = 0; md < 2; md++) begin
            enter_req  = 1'b1;
            enter_mode = md[1:0];
            bus_req    = 3'b110;
            @(negedge clk);
            enter_req = 1'b0;
            for (int c = 0; c < 3; c++) begin
                chk_full_on("R2 ignored mode");
                chk("R2 bus passes", int'(bus_req_out), 6);
                @(negedge clk);
            end
        end
    endtask

    task automatic run_nap();
        reset_dut();
        bus_req    = 3'b011;
        enter_req  = 1'b1;
        enter_mode = 2'b10;
        @(negedge clk);
        enter_req = 1'b0;
        chk("R3 nap gnt drop", core_mem_gnt, 0);
        chk("R3 nap quiesce", quiesce, 0);
        chk("R3 nap bus", int'(bus_req_out), 3);
        repeat (2) @(negedge clk);
        chk("R3 nap gnt hold", core_mem_gnt, 0);
        core_rdy = 1'b1;
        #1;
        chk("R3 nap gnt before edge", core_mem_gnt, 0);
        @(negedge clk);
        chk("R3 nap gnt restored", core_mem_gnt, 1);
        chk("R3 nap units", units_en, 1);
    endtask

    // src 0: timer wake, src k>0: bus master k-1
    task automatic run_sys(input int flag, input int src, input int tmo, input int lat, input int idx);
        int mstar;
        int req_exp;
        reset_dut();
        lock_tmo   = tmo[TW-1:0];
        enter_req  = 1'b1;
        enter_mode = 2'b11;
        mem_lp_en  = flag[0];
        @(negedge clk);
        enter_req = 1'b0;
        mem_lp_en = ~flag[0];   // R8: must not matter any more
        chk("R4 quiesce", quiesce, 1);
        chk("R4 sleep_en", sleep_en, 1);
        chk("R4 units_en", units_en, 0);
        chk("R4 mclk_en", mclk_en, 1 - flag);
        chk("R4 dll_en", dll_en, 1 - flag);
        chk("R4 mem_ctl_en", mem_ctl_en, 1 - flag);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R5 no wake holds", quiesce, 1);
            chk("R5 no wake units", units_en, 0);
            chk("R8 dll path idle", dll_en, 1 - flag);
        end
        if (src == 0) core_tb_wake = 1'b1;
        else          bus_req[src-1] = 1'b1;
        req_exp = (src == 0) ? 0 : (1 << (src - 1));
        #1;
        chk("R11 held in sleep", int'(bus_req_out), 0);
        @(negedge clk);
        chk("R5 one edge latency", units_en, 0);
        chk("R5 one edge dll", dll_en, 1 - flag);
        @(negedge clk);
        if (flag != 0) begin
            chk("R6 dll_en first", dll_en, 1);
            chk("R6 mem_ctl_en first", mem_ctl_en, 1);
            chk("R6 mclk off", mclk_en, 0);
            mstar = ((lat < tmo) ? lat : tmo) + 1;
            for (int m = 1; m <= mstar; m++) begin
                if (m - 1 == lat) dll_lock = 1'b1;
                @(negedge clk);
                if (m < mstar) begin
                    chk("R6 mclk waits", mclk_en, 0);
                    chk("R6 units wait", units_en, 0);
                end else begin
                    chk("R7 resume cycle mclk", mclk_en, 1);
                    chk("R6 sr_exit pulse", sr_exit, 1);
                    chk("R7 timeout flag", dll_err, (lat > tmo) ? 1 : 0);
                end
            end
            @(negedge clk);
            chk("R6 sr_exit single", sr_exit, 0);
        end else begin
            chk("R8 no dll wait mclk", mclk_en, 1);
            chk("R8 no sr_exit", sr_exit, 0);
        end
        chk("R9 units_en", units_en, 1);
        chk("R9 core_irq", core_irq, 1);
        chk("R11 still held", int'(bus_req_out), 0);
        repeat (2) @(negedge clk);
        chk("R9 irq held", core_irq, 1);
        core_irq_ack = 1'b1;
        @(negedge clk);
        core_irq_ack = 1'b0;
        chk("R9 irq cleared", core_irq, 0);
        for (int k = 0; k <= NU; k++) begin
            int item = (idx + k) % (NU + 1);
            if (item == NU) core_rdy = 1'b1;
            else            unit_rdy[item] = 1'b1;
            @(negedge clk);
            chk("R10 partial or unregistered", quiesce, 1);
            chk("R11 held until full-on", int'(bus_req_out), 0);
        end
        @(negedge clk);
        chk("R10 quiesce cleared", quiesce, 0);
        chk("R10 sleep_en cleared", sleep_en, 0);
        chk("R10 mem gnt", core_mem_gnt, 1);
        chk("R11 released", int'(bus_req_out), req_exp);
        chk("R7 sticky", dll_err, (flag != 0 && lat > tmo) ? 1 : 0);
        bus_req = 3'b101;
        #1;
        chk("R11 passthrough", int'(bus_req_out), 5);
        inputs_idle();
    endtask

    initial begin
        rst_n = 1'b0;
        lock_tmo = '0;
        inputs_idle();
        run_doze();
        run_nap();
        for (int src = 0; src <= NM; src++)
            run_sys(0, src, 2, 0, src);
        for (int src = 0; src <= NM; src++)
            for (int t = 0; t < 4; t++)
                for (int l = 0; l < 5; l++)
                    run_sys(1, src, t, l, src * 20 + t * 5 + l);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule